// File: doc/BRIEF.md
# T1 Receive Data Link Extractor and Router

The block sits behind a T1 receive framer that has already found frame alignment. It sees one received bit per 1.544 MHz clock, together with a pulse that marks the framing bit of the first frame of a superframe. From this it tracks bit and frame position and identifies the framing-bit slots that carry overhead for the data link. In ESF operation these slots are the facility data link bits. In N / SLC96 operation they are the signalling-framing bits.

A 2-bit route select steers each extracted overhead bit to one of three places. The controller strobe port feeds a link controller or buffer. The overhead port carries a one-cycle overhead clock enable. The serial output can also overwrite every overhead slot with a one. The serial output always carries the received stream, delayed by one register.

For ESF the overhead clock can mark every data link bit. It can also mark only the even-numbered or only the odd-numbered ones, at half rate. Route select and framing mode are sampled only at a superframe boundary.

Top module: `t1_dl_router`

## Requirements
- R1: While rst_n is low at a clock edge, every output is 0 after that edge.
- R2: With route select 00 (controller), each overhead bit raises link_strobe for one cycle with link_bit equal to that bit. ser_out equals rx_data from the previous cycle in every cycle, overhead slots included.
- R3: With route select 01 (serial only), link_strobe, link_bit, oh_clk_en and oh_data stay 0. ser_out equals rx_data from the previous cycle. With any other select, only the selected destination shows overhead bits.
- R4: With route select 10 (overhead port), each picked overhead bit raises oh_clk_en for one cycle with oh_data equal to that bit. ser_out still passes the stream unchanged.
- R5: With route select 11 (force ones), ser_out is 1 in the cycle after every overhead slot and equals the delayed rx_data elsewhere. The other outputs stay 0.
- R6: frame_sync marks bit 0 of frame 1 (frames numbered from 1, bits 0 to 192). In ESF mode (frame_mode = 0) the overhead slots are bit 0 of the odd frames 1 to 23 of a 24-frame superframe, which gives 12 slots. Before the first frame_sync after reset, no slot is treated as overhead.
- R7: In N / SLC96 mode (frame_mode = 1) the superframe is 12 frames long. The overhead slots are bit 0 of the even frames 2 to 12, which gives 6 slots.
- R8: In ESF mode, with oh_half_rate = 1, the overhead bits are numbered 1 to 12 within the superframe. oh_clk_en marks only the even-numbered bits when oh_odd_phase = 0 and only the odd-numbered bits when oh_odd_phase = 1. In N / SLC96 mode oh_half_rate has no effect and every slot is marked.
- R9: link_sel and frame_mode take effect only at a superframe boundary (bit 0 of frame 1). A change elsewhere leaves routing and slot positions unchanged until the next boundary. oh_half_rate and oh_odd_phase act at once.
- R10: All outputs change one clock after the input bit they depend on.
- R11: oh_clk_en is never high in two consecutive cycles, and oh_data is 0 whenever oh_clk_en is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 1.544 MHz bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_data | input | 1 | Received T1 bit |
| frame_sync | input | 1 | High on bit 0 of frame 1 |
| frame_mode | input | 1 | 0 = ESF, 1 = N / SLC96 |
| link_sel | input | 2 | Route select: 00 controller, 01 serial only, 10 overhead port, 11 force ones |
| oh_half_rate | input | 1 | ESF overhead clock at half rate |
| oh_odd_phase | input | 1 | Half-rate phase: 0 even-numbered, 1 odd-numbered bits |
| ser_out | output | 1 | Serial data out |
| oh_data | output | 1 | Overhead data |
| oh_clk_en | output | 1 | Overhead clock enable |
| link_bit | output | 1 | Bit toward the link controller |
| link_strobe | output | 1 | Valid strobe for link_bit |

## Verification
The assertions assume three things about the inputs. frame_sync arrives only on a frame-1 framing bit, or as a deliberate realignment. The clock runs once per received bit. Reset is held for at least one edge before the checks apply. The stimulus respects this. It pulses frame_sync only in the first cycle of a superframe it starts, otherwise lets the internal counters wrap, and changes select or mode mid-superframe only in the boundary-sampling test. Received bits are drawn at random, so overhead and payload values differ from one superframe to the next.

// File: rtl/t1dl_pkg.sv
// Package: shared route-select encoding and frame geometry for the
// T1 receive data link router. Assumes a 193-bit T1 frame.
package t1dl_pkg;
    typedef enum logic [1:0] {
        SEL_CTRL = 2'b00,
        SEL_SER  = 2'b01,
        SEL_OH   = 2'b10,
        SEL_ONES = 2'b11
    } dl_sel_e;

    localparam int T1_FRAME_BITS = 193;
    localparam int ESF_SF_FRAMES = 24;
    localparam int NSLC_SF_FRAMES = 12;
endpackage

// File: rtl/t1dl_locator.sv
// Module: t1dl_locator
// Tracks bit and frame position from frame_sync. Flags the overhead slot
// for the active framing mode, numbers the overhead bits and decides
// whether the overhead clock marks the current one. Samples the route
// select and the mode at each superframe boundary.
// Assumes: frame_sync is high only on bit 0 of frame 1.
module t1dl_locator
    import t1dl_pkg::*;
#(
    parameter int FRAME_BITS = T1_FRAME_BITS,
    parameter int ESF_FRAMES = ESF_SF_FRAMES,
    parameter int N_FRAMES   = NSLC_SF_FRAMES
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    frame_sync,
    input  logic    frame_mode,
    input  logic [1:0] link_sel,
    input  logic    oh_half_rate,
    input  logic    oh_odd_phase,
    output logic    is_dl,
    output logic    oh_pick,
    output dl_sel_e act_sel
);
    localparam int BW = $clog2(FRAME_BITS);
    localparam int FW = $clog2(ESF_FRAMES + 1);

    logic [BW-1:0] bit_q, cur_bit;
    logic [FW-1:0] frm_q, cur_frm, dl_num, sf_len;
    logic          lock_q, aligned, boundary, mode_q, act_mode;
    dl_sel_e       sel_q;

    // Current position: a sync pulse overrides the running counters.
    always_comb begin
        cur_bit  = frame_sync ? '0 : bit_q;
        cur_frm  = frame_sync ? FW'(1) : frm_q;
        aligned  = frame_sync | lock_q;
        boundary = aligned && (cur_bit == '0) && (cur_frm == FW'(1));
        act_sel  = boundary ? dl_sel_e'(link_sel) : sel_q;
        act_mode = boundary ? frame_mode : mode_q;
        sf_len   = act_mode ? FW'(N_FRAMES) : FW'(ESF_FRAMES);
    end

    // Overhead slot detection, bit numbering and half-rate pick.
    always_comb begin
        is_dl   = aligned && (cur_bit == '0) &&
                  (act_mode ? !cur_frm[0] : cur_frm[0]);
        dl_num  = act_mode ? (cur_frm >> 1) : ((cur_frm + FW'(1)) >> 1);
        oh_pick = act_mode || !oh_half_rate || (dl_num[0] == oh_odd_phase);
    end

    // Position counters, lock flag and boundary-sampled configuration.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_q  <= '0;
            frm_q  <= FW'(1);
            lock_q <= 1'b0;
            sel_q  <= SEL_SER;
            mode_q <= 1'b0;
        end else begin
            lock_q <= aligned;
            sel_q  <= act_sel;
            mode_q <= act_mode;
            if (cur_bit == BW'(FRAME_BITS - 1)) begin
                bit_q <= '0;
                frm_q <= (cur_frm == sf_len) ? FW'(1) : cur_frm + FW'(1);
            end else begin
                bit_q <= cur_bit + BW'(1);
                frm_q <= cur_frm;
            end
        end
    end

    // R6: frame counter stays within the longest superframe.
    assert_frame_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_q >= FW'(1)) && (frm_q <= FW'(ESF_FRAMES)));
    // R6: bit counter stays within one frame.
    assert_bit_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bit_q < BW'(FRAME_BITS));
    // R6: a sync pulse restarts the count at bit 1 of frame 1.
    assert_sync_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
        frame_sync |=> (bit_q == BW'(1)) && (frm_q == FW'(1)));
endmodule

// File: rtl/t1dl_steer.sv
// Module: t1dl_steer
// Registers the four destinations from the slot flag and the active
// route select. All outputs are one register after the input bit.
module t1dl_steer
    import t1dl_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    rx_data,
    input  logic    is_dl,
    input  logic    oh_pick,
    input  dl_sel_e act_sel,
    output logic    ser_out,
    output logic    oh_data,
    output logic    oh_clk_en,
    output logic    link_bit,
    output logic    link_strobe
);
    logic to_ctrl, to_oh, force_one;

    // Destination decode for the current bit.
    always_comb begin
        to_ctrl   = is_dl && (act_sel == SEL_CTRL);
        to_oh     = is_dl && (act_sel == SEL_OH) && oh_pick;
        force_one = is_dl && (act_sel == SEL_ONES);
    end

    // Output registers with idle reset values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ser_out     <= 1'b0;
            oh_data     <= 1'b0;
            oh_clk_en   <= 1'b0;
            link_bit    <= 1'b0;
            link_strobe <= 1'b0;
        end else begin
            ser_out     <= force_one ? 1'b1 : rx_data;
            oh_clk_en   <= to_oh;
            oh_data     <= to_oh & rx_data;
            link_strobe <= to_ctrl;
            link_bit    <= to_ctrl & rx_data;
        end
    end

    // R5: forced slots come out as one.
    assert_ser_force_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (is_dl && act_sel == SEL_ONES) |=> ser_out);
    // R2: outside overhead slots the stream passes unchanged.
    assert_ser_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !is_dl |=> (ser_out == $past(rx_data)));
    // R11: overhead clock is a single-cycle enable.
    assert_ohclk_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        oh_clk_en |=> !oh_clk_en);
    // R11: overhead data idle while its clock is low.
    assert_ohdata_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !oh_clk_en |-> !oh_data);
    // R4: overhead data carries the extracted bit.
    assert_ohdata_val_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (is_dl && act_sel == SEL_OH && oh_pick) |=> (oh_data == $past(rx_data)));
    // R2: link bit idle without its strobe.
    assert_linkbit_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !link_strobe |-> !link_bit);
    // R3: at most one extra destination is active per cycle.
    assert_dest_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({link_strobe, oh_clk_en}));
endmodule

// File: rtl/t1_dl_router.sv
// Module: t1_dl_router (top)
// T1 receive data link extractor and router. Joins the position locator
// and the output steering stage. Assumes the stream is frame aligned and
// that frame_sync marks bit 0 of frame 1.
module t1_dl_router
    import t1dl_pkg::*;
#(
    parameter int FRAME_BITS = T1_FRAME_BITS,
    parameter int ESF_FRAMES = ESF_SF_FRAMES,
    parameter int N_FRAMES   = NSLC_SF_FRAMES
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_data,
    input  logic       frame_sync,
    input  logic       frame_mode,
    input  logic [1:0] link_sel,
    input  logic       oh_half_rate,
    input  logic       oh_odd_phase,
    output logic       ser_out,
    output logic       oh_data,
    output logic       oh_clk_en,
    output logic       link_bit,
    output logic       link_strobe
);
    logic    is_dl, oh_pick;
    dl_sel_e act_sel;

    t1dl_locator #(
        .FRAME_BITS(FRAME_BITS),
        .ESF_FRAMES(ESF_FRAMES),
        .N_FRAMES  (N_FRAMES)
    ) loc_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_sync  (frame_sync),
        .frame_mode  (frame_mode),
        .link_sel    (link_sel),
        .oh_half_rate(oh_half_rate),
        .oh_odd_phase(oh_odd_phase),
        .is_dl       (is_dl),
        .oh_pick     (oh_pick),
        .act_sel     (act_sel)
    );

    t1dl_steer steer_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_data    (rx_data),
        .is_dl      (is_dl),
        .oh_pick    (oh_pick),
        .act_sel    (act_sel),
        .ser_out    (ser_out),
        .oh_data    (oh_data),
        .oh_clk_en  (oh_clk_en),
        .link_bit   (link_bit),
        .link_strobe(link_strobe)
    );

    // R1: outputs idle in the cycle after a reset edge.
    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> !(ser_out | oh_data | oh_clk_en | link_bit | link_strobe));
endmodule

// File: tb/t1_dl_router_tb.sv
// Bench for t1_dl_router: a table of route configurations walked by one
// loop, each run over a full superframe against a reference model, then
// directed tests for reset, pre-sync and boundary sampling.
module t1_dl_router_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int FB = 193;
    localparam int ROWS = 9;
    // Row fields: {mode, sel[1:0], half, odd, exp_strobes[3:0], exp_ohclk[3:0]}
    localparam logic [12:0] VEC [ROWS] = '{
        {1'b0, 2'b00, 1'b0, 1'b0, 4'd12, 4'd0},
        {1'b0, 2'b01, 1'b0, 1'b0, 4'd0,  4'd0},
        {1'b0, 2'b10, 1'b0, 1'b0, 4'd0,  4'd12},
        {1'b0, 2'b10, 1'b1, 1'b0, 4'd0,  4'd6},
        {1'b0, 2'b10, 1'b1, 1'b1, 4'd0,  4'd6},
        {1'b0, 2'b11, 1'b0, 1'b0, 4'd0,  4'd0},
        {1'b1, 2'b00, 1'b0, 1'b0, 4'd6,  4'd0},
        {1'b1, 2'b10, 1'b1, 1'b1, 4'd0,  4'd6},
        {1'b1, 2'b11, 1'b0, 1'b0, 4'd0,  4'd0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_data = 1'b0, frame_sync = 1'b0, frame_mode = 1'b0;
    logic [1:0] link_sel = 2'b01;
    logic oh_half_rate = 1'b0, oh_odd_phase = 1'b0;
    logic ser_out, oh_data, oh_clk_en, link_bit, link_strobe;

    int n_checks = 0, n_fail = 0;
    int m_bit = 0, m_frm = 1, m_sel = 1;
    logic m_lock = 1'b0, m_mode = 1'b0;
    int mm_ser, mm_oh, mm_st, act_st, act_oh;

    always #(CLK_PERIOD/2) clk = ~clk;

    t1_dl_router dut_i (
        .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .frame_sync(frame_sync),
        .frame_mode(frame_mode), .link_sel(link_sel), .oh_half_rate(oh_half_rate),
        .oh_odd_phase(oh_odd_phase), .ser_out(ser_out), .oh_data(oh_data),
        .oh_clk_en(oh_clk_en), .link_bit(link_bit), .link_strobe(link_strobe)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_counts();
        mm_ser = 0; mm_oh = 0; mm_st = 0; act_st = 0; act_oh = 0;
    endtask

    // One bit through model and DUT; compared one clock later (R10).
    task automatic tick(input logic d, input logic sync);
        int b, f, k, len;
        logic al, dl, pick, e_ser, e_oh, e_ohd, e_st, e_lb;
        b = sync ? 0 : m_bit;
        f = sync ? 1 : m_frm;
        al = sync | m_lock;
        if (al && b == 0 && f == 1) begin
            m_sel = int'(link_sel);
            m_mode = frame_mode;
        end
        dl = al && b == 0 && (m_mode ? (f % 2 == 0) : (f % 2 == 1));
        k = m_mode ? f / 2 : (f + 1) / 2;
        pick = m_mode || !oh_half_rate || ((k % 2) == int'(oh_odd_phase));
        e_ser = (dl && m_sel == 3) ? 1'b1 : d;
        e_oh = dl && m_sel == 2 && pick;
        e_ohd = e_oh & d;
        e_st = dl && m_sel == 0;
        e_lb = e_st & d;
        len = m_mode ? 12 : 24;
        m_lock = al;
        if (b == FB - 1) begin
            m_bit = 0;
            m_frm = (f == len) ? 1 : f + 1;
        end else begin
            m_bit = b + 1;
            m_frm = f;
        end
        rx_data = d;
        frame_sync = sync;
        @(posedge clk);
        @(negedge clk);
        if (ser_out !== e_ser) mm_ser++;
        if (oh_clk_en !== e_oh || oh_data !== e_ohd) mm_oh++;
        if (link_strobe !== e_st || link_bit !== e_lb) mm_st++;
        if (link_strobe === 1'b1) act_st++;
        if (oh_clk_en === 1'b1) act_oh++;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        frame_sync = 1'b0;
        repeat (3) @(negedge clk);
        // R1: idle outputs during reset
        check({ser_out, oh_data, oh_clk_en, link_bit, link_strobe} == 5'b0, "R1",
              int'({ser_out, oh_data, oh_clk_en, link_bit, link_strobe}), 0);
        m_bit = 0; m_frm = 1; m_sel = 1; m_lock = 1'b0; m_mode = 1'b0;
        rst_n = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();

        // Pre-sync: no overhead slots even with force-ones requested (R6)
        link_sel = 2'b11;
        clear_counts();
        for (int i = 0; i < 3 * FB; i++) tick(1'b0, 1'b0);
        check(mm_ser == 0 && act_st == 0, "R6", mm_ser + act_st, 0);

        // Table of route configurations
        for (int r = 0; r < ROWS; r++) begin
            logic [12:0] v;
            int len, es, eo;
            v = VEC[r];
            frame_mode = v[12];
            link_sel = v[11:10];
            oh_half_rate = v[9];
            oh_odd_phase = v[8];
            es = int'(v[7:4]);
            eo = int'(v[3:0]);
            len = v[12] ? 12 : 24;
            clear_counts();
            for (int i = 0; i < len * FB; i++) tick(1'($urandom_range(0, 1)), i == 0);
            check(mm_ser == 0, (v[11:10] == 2'b11) ? "R5" : "R2", mm_ser, 0);
            check(mm_st == 0, (v[11:10] == 2'b00) ? "R2" : "R3", mm_st, 0);
            check(mm_oh == 0, (v[11:10] == 2'b10) ? "R11" : "R3", mm_oh, 0);
            check(act_st == es, v[12] ? "R7" : "R6", act_st, es);
            check(act_oh == eo, v[9] ? "R8" : "R4", act_oh, eo);
        end

        // R9: mid-superframe change waits for the boundary
        frame_mode = 1'b0;
        link_sel = 2'b00;
        oh_half_rate = 1'b0;
        clear_counts();
        for (int i = 0; i < 24 * FB; i++) begin
            if (i == 5 * FB + 7) begin
                link_sel = 2'b10;
                frame_mode = 1'b1;
            end
            tick(1'($urandom_range(0, 1)), i == 0);
        end
        check(act_st == 12 && act_oh == 0, "R9", act_st * 100 + act_oh, 1200);
        check(mm_st == 0 && mm_oh == 0 && mm_ser == 0, "R9", mm_st + mm_oh + mm_ser, 0);
        clear_counts();
        for (int i = 0; i < 12 * FB; i++) tick(1'($urandom_range(0, 1)), 1'b0);
        check(act_st == 0 && act_oh == 6, "R9", act_st * 100 + act_oh, 6);
        check(mm_oh == 0 && mm_ser == 0, "R7", mm_oh + mm_ser, 0);

        // Reset in mid-run returns outputs to idle (R1)
        link_sel = 2'b11;
        for (int i = 0; i < 10; i++) tick(1'b1, 1'b0);
        do_reset();

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule